// File: doc/BRIEF.md
# Dual-Output Binary Field Multiplier and Squarer

This block computes, for elements of a binary extension field GF(2^K) in polynomial basis, both the product of two operands and the square of the first operand, in a single pass over one shared datapath. Each loop cycle consumes two coefficients of each operand. A running value A·α^(2i) is kept, and four accumulators take its contributions. Two of them collect the even-indexed coefficient terms and two collect the odd-indexed terms, one pair for the product and one pair for the square. A closing cycle merges each odd accumulator into its even partner. The merge is a single multiplication by α and one reduction.

The field polynomial is presented as its K low coefficients, with the leading coefficient understood to be one. The caller also supplies the constant α^(K+1) mod H. A client raises a one-cycle start with the operands valid. It later sees a one-cycle done, and from then on both results stay on the outputs until the next accepted start. The block is intended as the arithmetic core of a right-to-left exponentiation or point-arithmetic engine, where a multiply and a square are needed together.

Top module: `gf_ms_top`

## Requirements
- R1: When done pulses, prod_o equals op_a_i·op_b_i mod H, with both operands taken from the cycle in which start_i was accepted.
- R2: In the same done cycle, sqr_o equals op_a_i·op_a_i mod H.
- R3: poly_h_i bit j is coefficient h_j of H = x^K + Σ h_j x^j, for j = 0..K-1. poly_hp_i bit j is coefficient j of α^(K+1) mod H.
- R4: With G = ceil(K/2), done_o rises exactly G+1 clock cycles after the edge that accepts start_i, and it is high for one cycle only.
- R5: prod_o and sqr_o change only in a cycle where done_o is high. They hold their values while the inputs change between operations.
- R6: A start_i raised while an operation is in progress is ignored. The running operation completes with its original operands and its original timing.
- R7: For odd K, the results are correct. In the final loop cycle, the odd-coefficient accumulators do not change.
- R8: After reset, done_o is 0, prod_o and sqr_o are 0, and the block is idle and accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts an operation when the block is idle |
| op_a_i | input | K | Operand A, bit j is the coefficient of x^j |
| op_b_i | input | K | Operand B, bit j is the coefficient of x^j |
| poly_h_i | input | K | Low K coefficients of the field polynomial |
| poly_hp_i | input | K | Precomputed α^(K+1) mod H |
| done_o | output | 1 | One-cycle pulse when results are valid |
| prod_o | output | K | A·B mod H |
| sqr_o | output | K | A·A mod H |

## Verification
Two instances run side by side. One has an even width (K=8), and one has an odd width (K=5), so the missing final odd pair is exercised. Each instance runs random operands under three polynomials, which separates real reduction from a result that only happens to be right under one modulus. Fixed patterns isolate particular paths:
- a zero operand checks that the accumulators are cleared between runs;
- B=1 makes the product return A, which isolates the even accumulator path;
- all-ones operands drive every reduction term.

A start issued mid-operation and input changes after done show that accepted state is latched and that the outputs are held.

// File: rtl/gf_ms_pkg.sv
package gf_ms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_FOLD = 2'd2
    } ms_state_e;

    localparam int unsigned LANES = 4;
    localparam int unsigned LANE_C = 0;
    localparam int unsigned LANE_D = 1;
    localparam int unsigned LANE_Q = 2;
    localparam int unsigned LANE_R = 3;
endpackage

// File: rtl/gf_ms_alpha2.sv
module gf_ms_alpha2 #(
    parameter int unsigned K = 8
) (
    input  logic [K-1:0] run_i,
    input  logic [K-1:0] h_i,
    input  logic [K-1:0] hp_i,
    output logic [K-1:0] run_o
);
    logic top_k1;
    logic top_k2;

    assign top_k1 = run_i[K-1];
    assign top_k2 = run_i[K-2];

    for (genvar j = 0; j < K; j++) begin : g_bit
        if (j >= 2) begin : g_shift
            assign run_o[j] = run_i[j-2] ^ (top_k2 & h_i[j]) ^ (top_k1 & hp_i[j]);
        end else begin : g_low
            assign run_o[j] = (top_k2 & h_i[j]) ^ (top_k1 & hp_i[j]);
        end
    end

    always_comb begin
        if (!top_k1 && !top_k2) begin
            p_plain_shift_r3: assert (run_o == (run_i << 2));
        end
    end
endmodule

// File: rtl/gf_ms_acc_lane.sv
module gf_ms_acc_lane #(
    parameter int unsigned K = 8
) (
    input  logic [K-1:0] acc_i,
    input  logic [K-1:0] run_i,
    input  logic         gate_i,
    output logic [K-1:0] acc_o
);
    assign acc_o = acc_i ^ (run_i & {K{gate_i}});

    always_comb begin
        if (!gate_i) begin
            p_gate_off_r7: assert (acc_o == acc_i);
        end
    end
endmodule

// File: rtl/gf_ms_fold.sv
module gf_ms_fold #(
    parameter int unsigned K = 8
) (
    input  logic [K-1:0] even_i,
    input  logic [K-1:0] odd_i,
    input  logic [K-1:0] h_i,
    output logic [K-1:0] res_o
);
    logic [K-1:0] odd_times_alpha;
    logic         carry;

    assign carry = odd_i[K-1];
    assign odd_times_alpha = {odd_i[K-2:0], 1'b0} ^ (h_i & {K{carry}});
    assign res_o = even_i ^ odd_times_alpha;
endmodule

// File: rtl/gf_ms_top.sv
module gf_ms_top
    import gf_ms_pkg::*;
#(
    parameter int unsigned K = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [K-1:0] op_a_i,
    input  logic [K-1:0] op_b_i,
    input  logic [K-1:0] poly_h_i,
    input  logic [K-1:0] poly_hp_i,
    output logic         done_o,
    output logic [K-1:0] prod_o,
    output logic [K-1:0] sqr_o
);
    localparam int unsigned G      = (K + 1) / 2;
    localparam int unsigned IW     = (G > 1) ? $clog2(G) : 1;
    localparam bit          K_ODD  = (K % 2) == 1;
    localparam logic [IW-1:0] LAST = IW'(G - 1);

    typedef struct packed {
        ms_state_e                 state;
        logic [IW-1:0]             iter;
        logic [K-1:0]              run;
        logic [K-1:0]              a_org;
        logic [K-1:0]              b_org;
        logic [K-1:0]              h;
        logic [K-1:0]              hp;
        logic [LANES-1:0][K-1:0]   acc;
        logic [K-1:0]              prod;
        logic [K-1:0]              sqr;
        logic                      done;
    } ms_regs_t;

    ms_regs_t r_q, r_d;

    logic [K-1:0]            run_next;
    logic [LANES-1:0][K-1:0] acc_next;
    logic [LANES-1:0]        gate;
    logic [K-1:0]            prod_fold;
    logic [K-1:0]            sqr_fold;
    logic [K-1:0]            a_shifted;
    logic [K-1:0]            b_shifted;
    logic                    odd_present;
    logic [$clog2(K)+1:0]    odd_index;

    // coefficient selection for the current iteration
    always_comb begin
        a_shifted   = r_q.a_org >> {r_q.iter, 1'b0};
        b_shifted   = r_q.b_org >> {r_q.iter, 1'b0};
        odd_index   = {r_q.iter, 1'b1};
        odd_present = (odd_index < K);
        gate[LANE_C] = b_shifted[0];
        gate[LANE_D] = b_shifted[1] & odd_present;
        gate[LANE_Q] = a_shifted[0];
        gate[LANE_R] = a_shifted[1] & odd_present;
    end

    gf_ms_alpha2 #(.K(K)) u_alpha2 (
        .run_i (r_q.run),
        .h_i   (r_q.h),
        .hp_i  (r_q.hp),
        .run_o (run_next)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        gf_ms_acc_lane #(.K(K)) u_lane (
            .acc_i  (r_q.acc[l]),
            .run_i  (r_q.run),
            .gate_i (gate[l]),
            .acc_o  (acc_next[l])
        );
    end

    gf_ms_fold #(.K(K)) u_fold_prod (
        .even_i (r_q.acc[LANE_C]),
        .odd_i  (r_q.acc[LANE_D]),
        .h_i    (r_q.h),
        .res_o  (prod_fold)
    );

    gf_ms_fold #(.K(K)) u_fold_sqr (
        .even_i (r_q.acc[LANE_Q]),
        .odd_i  (r_q.acc[LANE_R]),
        .h_i    (r_q.h),
        .res_o  (sqr_fold)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_LOOP;
                    r_d.iter  = '0;
                    r_d.run   = op_a_i;
                    r_d.a_org = op_a_i;
                    r_d.b_org = op_b_i;
                    r_d.h     = poly_h_i;
                    r_d.hp    = poly_hp_i;
                    r_d.acc   = '0;
                end
            end
            ST_LOOP: begin
                r_d.acc = acc_next;
                r_d.run = run_next;
                if (r_q.iter == LAST) begin
                    r_d.state = ST_FOLD;
                end else begin
                    r_d.iter = r_q.iter + 1'b1;
                end
            end
            ST_FOLD: begin
                r_d.prod  = prod_fold;
                r_d.sqr   = sqr_fold;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign prod_o = r_q.prod;
    assign sqr_o  = r_q.sqr;

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_fold_then_done_r4: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_FOLD) |=> done_o);

    p_iter_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_LOOP) |-> (r_q.iter <= LAST));

    p_outputs_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable({prod_o, sqr_o}) |-> done_o);

    p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_LOOP && r_q.iter != LAST && start_i)
            |=> (r_q.state == ST_LOOP && r_q.iter == $past(r_q.iter) + 1'b1));

    p_acc_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_LOOP && r_q.iter == '0) |-> (r_q.acc == '0));

    p_odd_lanes_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (K_ODD && r_q.state == ST_LOOP && r_q.iter == LAST)
            |=> (r_q.acc[LANE_D] == $past(r_q.acc[LANE_D])
                 && r_q.acc[LANE_R] == $past(r_q.acc[LANE_R])));

    p_idle_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (r_q.state == ST_IDLE));
endmodule

// File: tb/gf_ms_top_test.sv
module gf_ms_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int KE = 8;
    localparam int KO = 5;

    typedef struct {
        logic [63:0] p;
        logic [63:0] s;
        int          t;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;

    logic          st_e = 0, st_o = 0;
    logic [KE-1:0] a_e = 0, b_e = 0, h_e = 0, hp_e = 0;
    logic [KO-1:0] a_o = 0, b_o = 0, h_o = 0, hp_o = 0;
    logic          done_e, done_o;
    logic [KE-1:0] p_e, s_e;
    logic [KO-1:0] p_o, s_o;

    exp_t q_e[$];
    exp_t q_o[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gf_ms_top #(.K(KE)) uut (
        .clk(clk), .rst(rst), .start_i(st_e), .op_a_i(a_e), .op_b_i(b_e),
        .poly_h_i(h_e), .poly_hp_i(hp_e), .done_o(done_e), .prod_o(p_e), .sqr_o(s_e)
    );

    gf_ms_top #(.K(KO)) uut_odd (
        .clk(clk), .rst(rst), .start_i(st_o), .op_a_i(a_o), .op_b_i(b_o),
        .poly_h_i(h_o), .poly_hp_i(hp_o), .done_o(done_o), .prod_o(p_o), .sqr_o(s_o)
    );

    function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] h, input int k);
        logic [63:0] r, m;
        logic top;
        m = (64'd1 << k) - 1;
        r = 0;
        for (int i = k - 1; i >= 0; i--) begin
            top = r[k-1];
            r = (r << 1) & m;
            if (top) r = r ^ h;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_hp(input logic [63:0] h, input int k);
        logic [63:0] r;
        r = ((h << 1) & ((64'd1 << k) - 1));
        if (h[k-1]) r = r ^ h;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // driver: pushes expected results, then pulses start
    task automatic drive(input bit odd, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] h);
        exp_t e;
        int k;
        k = odd ? KO : KE;
        e.p = ref_mul(a, b, h, k);
        e.s = ref_mul(a, a, h, k);
        @(negedge clk);
        e.t = cyc + 1;
        if (odd) begin
            a_o = a[KO-1:0]; b_o = b[KO-1:0]; h_o = h[KO-1:0];
            hp_o = ref_hp(h, KO)[KO-1:0]; st_o = 1; q_o.push_back(e);
        end else begin
            a_e = a[KE-1:0]; b_e = b[KE-1:0]; h_e = h[KE-1:0];
            hp_e = ref_hp(h, KE)[KE-1:0]; st_e = 1; q_e.push_back(e);
        end
        @(negedge clk);
        st_o = 0; st_e = 0;
    endtask

    task automatic wait_idle();
        while (q_e.size() != 0 || q_o.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitors
    always @(negedge clk) begin
        if (!rst && done_e) begin
            if (q_e.size() == 0) check(0, "R6 unexpected done (K=8)", 1, 0);
            else begin
                exp_t e;
                e = q_e.pop_front();
                check(p_e == e.p[KE-1:0], "R1 product K=8", 64'(p_e), e.p);
                check(s_e == e.s[KE-1:0], "R2 square K=8", 64'(s_e), e.s);
                check(cyc - e.t == (KE+1)/2 + 1, "R4 latency K=8", 64'(cyc - e.t), 64'((KE+1)/2 + 1));
            end
        end
        if (!rst && done_o) begin
            if (q_o.size() == 0) check(0, "R6 unexpected done (K=5)", 1, 0);
            else begin
                exp_t e;
                e = q_o.pop_front();
                check(p_o == e.p[KO-1:0], "R7 R1 product K=5", 64'(p_o), e.p);
                check(s_o == e.s[KO-1:0], "R7 R2 square K=5", 64'(s_o), e.s);
                check(cyc - e.t == (KO+1)/2 + 1, "R4 latency K=5", 64'(cyc - e.t), 64'((KO+1)/2 + 1));
            end
        end
    end

    // pulse width check
    logic done_e_prev = 0;
    always @(negedge clk) begin
        if (!rst && done_e && done_e_prev) check(0, "R4 done longer than one cycle", 1, 0);
        done_e_prev <= done_e;
    end

    initial begin
        logic [63:0] he [3];
        logic [63:0] ho [3];
        he[0] = 64'h1B; he[1] = 64'h1D; he[2] = 64'h63;
        ho[0] = 64'h05; ho[1] = 64'h09; ho[2] = 64'h0F;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        check(done_e == 0 && done_o == 0, "R8 done after reset", 64'(done_e), 0);
        check(p_e == 0 && s_e == 0 && p_o == 0 && s_o == 0, "R8 outputs after reset",
              64'({p_e, s_e}), 0);

        // fixed patterns, R3 polynomial coding via several H
        for (int pi = 0; pi < 3; pi++) begin
            drive(0, 64'h00, 64'h5A, he[pi]); wait_idle();
            drive(0, 64'hB7, 64'h01, he[pi]); wait_idle();
            drive(0, 64'hFF, 64'hFF, he[pi]); wait_idle();
            drive(1, 64'h00, 64'h13, ho[pi]); wait_idle();
            drive(1, 64'h16, 64'h01, ho[pi]); wait_idle();
            drive(1, 64'h1F, 64'h1F, ho[pi]); wait_idle();
        end

        // random operands on both widths
        for (int n = 0; n < 60; n++) begin
            drive(0, 64'($urandom), 64'($urandom), he[n % 3]);
            drive(1, 64'($urandom), 64'($urandom), ho[n % 3]);
            wait_idle();
        end

        // R6 start while busy is ignored
        drive(0, 64'h3C, 64'hA5, he[0]);
        @(negedge clk);
        a_e = 8'h11; b_e = 8'h22; st_e = 1;
        @(negedge clk);
        st_e = 0;
        wait_idle();
        check(q_e.size() == 0, "R6 queue drained after ignored start", 64'(q_e.size()), 0);

        // R5 outputs hold while inputs change
        begin
            logic [KE-1:0] hold_p, hold_s;
            drive(0, 64'h9E, 64'h47, he[1]); wait_idle();
            hold_p = p_e; hold_s = s_e;
            a_e = 8'h00; b_e = 8'hFF; h_e = 8'h00; hp_e = 8'hFF;
            repeat (6) @(negedge clk);
            check(p_e == hold_p, "R5 product held", 64'(p_e), 64'(hold_p));
            check(s_e == hold_s, "R5 square held", 64'(s_e), 64'(hold_s));
            check(done_e == 0, "R5 no spurious done", 64'(done_e), 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule